// File: doc/BRIEF.md
# Receiver Output Gating Controller

This block sits between the clock-and-data recovery logic of a serial-link receiver and its parallel output pads. It takes a 24-bit data word, a 3-bit control word and a recovered pixel clock. From a run enable (active-high; low means powered down), the link lock flag and a small set of configuration straps, it decides what the pads show. The pads can pass live data, be driven low, or be released to high impedance.

The straps share pins with the data outputs. Each time the block leaves power-down, it keeps the output enables off for a fixed four-clock window. On the last edge of that window it samples the pad levels into a strap word, which it also hands to neighbouring logic. Two strap bits matter here: a sleep-state select and a hold-low option. With hold-low set, the outputs stay low after lock until software sets a release bit through a one-bit register write port. Losing lock or entering power-down clears that bit again.

Top module: `rx_out_gate`

## Requirements
- R1: While `rstN` is low, `outEn`, `dataOut`, `ctrlOut`, `clkOut` and `strapWord` are all 0, so the pads float.
- R2: At each rising edge with `runEn` low, the outputs take the sleep state. `dataOut` and `ctrlOut` become 0. `outEn` becomes the sleep-low level, which is 1 when strap bit 18 or strap bit 20 of the last captured word is 1 and 0 otherwise. The encoding of bit 18 is 0 for high impedance and 1 for driven low.
- R3: For the first four rising edges at which `runEn` is high after being low, `outEn` is 0 after each of those edges. `strapWord` takes the value of `padIn` present at the fourth of those edges.
- R4: Strap bit 18 is the sleep-state select and strap bit 20 is the hold-low option. The captured word survives power-down and is cleared only by `rstN`.
- R5: After the window, a rising edge with `lockIn` low gives `dataOut` = 0, `ctrlOut` = 0 and `outEn` = sleep-low level.
- R6: After the window, with hold-low 0, a rising edge with `lockIn` high gives `outEn` = 1 and `dataOut`/`ctrlOut` equal to `dataIn`/`ctrlIn` sampled at that edge.
- R7: With hold-low 1, lock high and the release bit 0, the outputs are driven low (`outEn` = 1, data and control 0).
- R8: A write (`regWrEn` = 1) while locked after the window loads `regWrData` into the release bit at that edge. A 1 lets data pass from the next edge on. A 0 restores the hold.
- R9: The release bit clears at every edge with `lockIn` low. Writes made while unlocked have no effect, so the hold returns after each relock.
- R10: Power-down (`runEn` low) clears the release bit.
- R11: `clkOut` equals `pixClkIn` while data passes and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous supply-good reset, active low |
| runEn | input | 1 | Run enable; low means power-down |
| lockIn | input | 1 | Link lock flag from clock recovery |
| regWrEn | input | 1 | Release-bit write strobe |
| regWrData | input | 1 | Release-bit write value |
| padIn | input | 24 | Pad receiver levels used for strap capture |
| dataIn | input | 24 | Recovered data word |
| ctrlIn | input | 3 | Recovered control bits |
| pixClkIn | input | 1 | Recovered pixel clock |
| dataOut | output | 24 | Gated data to pads |
| ctrlOut | output | 3 | Gated control to pads |
| clkOut | output | 1 | Gated pixel clock to pads |
| outEn | output | 1 | Common output-driver enable |
| strapWord | output | 24 | Captured strap word |

## Verification
Every gated output is due one rising edge after the inputs that select it. A release write needs two edges before data passes: one to load the bit and one to use it. The strap word appears right after the fourth edge of the window. The bench drives inputs 1 ns after an edge and advances its own model of the expected state at the next edge. It then compares all ports 1 ns later, so each check lands in the first cycle where the result is due. Directed sequences place writes before and after relocks and power-downs. A seeded random phase then mixes lock drops, power-downs, writes and random strap levels.

// File: rtl/rxg_pkg.sv
`timescale 1ns/1ps
package rxg_pkg;
  typedef enum logic [1:0] {
    PH_SLEEP   = 2'd0,
    PH_CAPTURE = 2'd1,
    PH_RUN     = 2'd2
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic passEn;   // forward live data and clock
    logic driveEn;  // drive pads (low unless passEn)
  } gateStrobe_t;
endpackage

// File: rtl/rxg_ctrl.sv
`timescale 1ns/1ps
module rxg_ctrl
  import rxg_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int CAP_CYCLES = 4,   // must be 2 or more
  parameter int SLEEP_POS  = 18,
  parameter int HOLD_POS   = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              lockIn,
  input  logic              regWrEn,
  input  logic              regWrData,
  input  logic [DATA_W-1:0] padIn,
  output gateStrobe_t       strobe,
  output logic [DATA_W-1:0] strapWord,
  output logic              releaseQ,
  output logic              holdLowQ,
  output logic              capBusy
);
  localparam int CNT_W = (CAP_CYCLES > 2) ? $clog2(CAP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(CAP_CYCLES - 1);

  phase_t            phaseQ;
  logic [CNT_W-1:0]  capCnt;
  logic [DATA_W-1:0] strapQ;
  logic              sleepLow;
  logic              runLocked;

  // phase sequencing and strap capture; strap latch only cleared by rstN
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_SLEEP;
      capCnt <= '0;
      strapQ <= '0;
    end else if (!runEn) begin
      phaseQ <= PH_SLEEP;
      capCnt <= '0;
    end else begin
      case (phaseQ)
        PH_SLEEP: begin
          phaseQ <= PH_CAPTURE;
          capCnt <= CNT_FIRST;
        end
        PH_CAPTURE: begin
          if (capCnt == CNT_LAST) begin
            phaseQ <= PH_RUN;
            strapQ <= padIn;
          end else begin
            capCnt <= capCnt + 1'b1;
          end
        end
        PH_RUN:  phaseQ <= PH_RUN;
        default: phaseQ <= PH_SLEEP;
      endcase
    end
  end

  assign runLocked = runEn && (phaseQ == PH_RUN) && lockIn;

  // release register: writable only while locked, cleared otherwise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      releaseQ <= 1'b0;
    end else if (!runLocked) begin
      releaseQ <= 1'b0;
    end else if (regWrEn) begin
      releaseQ <= regWrData;
    end
  end

  assign holdLowQ  = strapQ[HOLD_POS];
  assign sleepLow  = strapQ[SLEEP_POS] | strapQ[HOLD_POS];
  assign strapWord = strapQ;
  assign capBusy   = runEn && (phaseQ != PH_RUN);

  always_comb begin
    strobe = '0;
    if (!runEn) begin
      strobe.driveEn = sleepLow;
    end else if (phaseQ == PH_RUN) begin
      if (lockIn) begin
        strobe.driveEn = 1'b1;
        strobe.passEn  = !holdLowQ || releaseQ;
      end else begin
        strobe.driveEn = sleepLow;
      end
    end
  end
endmodule

// File: rtl/rxg_datapath.sv
`timescale 1ns/1ps
module rxg_datapath
  import rxg_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CTRL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CTRL_W-1:0] ctrlIn,
  input  logic              pixClkIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic              clkOut,
  output logic              outEn
);
  localparam int LANES = DATA_W + CTRL_W;

  logic [LANES-1:0] laneIn;
  logic [LANES-1:0] laneQ;
  logic             clkPassQ;
  logic             enQ;

  assign laneIn = {ctrlIn, dataIn};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic bitQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bitQ <= 1'b0;
      else       bitQ <= laneIn[i] & strobe.passEn;
    end
    assign laneQ[i] = bitQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPassQ <= 1'b0;
      enQ      <= 1'b0;
    end else begin
      clkPassQ <= strobe.passEn;
      enQ      <= strobe.driveEn | strobe.passEn;
    end
  end

  assign dataOut = laneQ[DATA_W-1:0];
  assign ctrlOut = laneQ[LANES-1:DATA_W];
  assign clkOut  = pixClkIn & clkPassQ;
  assign outEn   = enQ;
endmodule

// File: rtl/rx_out_gate.sv
`timescale 1ns/1ps
module rx_out_gate
  import rxg_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int CTRL_W     = 3,
  parameter int CAP_CYCLES = 4,
  parameter int SLEEP_POS  = 18,
  parameter int HOLD_POS   = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              lockIn,
  input  logic              regWrEn,
  input  logic              regWrData,
  input  logic [DATA_W-1:0] padIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CTRL_W-1:0] ctrlIn,
  input  logic              pixClkIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic              clkOut,
  output logic              outEn,
  output logic [DATA_W-1:0] strapWord
);
  gateStrobe_t strobe;
  logic        releaseQ;
  logic        holdLowQ;
  logic        capBusy;

  rxg_ctrl #(
    .DATA_W(DATA_W), .CAP_CYCLES(CAP_CYCLES),
    .SLEEP_POS(SLEEP_POS), .HOLD_POS(HOLD_POS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .lockIn(lockIn),
    .regWrEn(regWrEn), .regWrData(regWrData), .padIn(padIn),
    .strobe(strobe), .strapWord(strapWord), .releaseQ(releaseQ),
    .holdLowQ(holdLowQ), .capBusy(capBusy)
  );

  rxg_datapath #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .ctrlIn(ctrlIn), .pixClkIn(pixClkIn), .dataOut(dataOut),
    .ctrlOut(ctrlOut), .clkOut(clkOut), .outEn(outEn)
  );
endmodule

// File: rtl/rx_out_gate_chk.sv
`timescale 1ns/1ps
module rx_out_gate_chk #(
  parameter int DATA_W = 24,
  parameter int CTRL_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              runEn,
  input logic              lockIn,
  input logic              outEn,
  input logic [DATA_W-1:0] dataOut,
  input logic [CTRL_W-1:0] ctrlOut,
  input logic              releaseQ,
  input logic              holdLowQ,
  input logic              capBusy
);
  AST_PDN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (dataOut == '0) && (ctrlOut == '0)); // R2
  AST_CAPTURE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    capBusy |=> !outEn); // R3
  AST_UNLOCK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !lockIn |=> (dataOut == '0) && (ctrlOut == '0)); // R5
  AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (dataOut != '0) |-> $past(!holdLowQ || releaseQ)); // R7
  AST_UNLOCK_CLEARS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !lockIn |=> !releaseQ); // R9
  AST_PDN_CLEARS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !releaseQ); // R10
endmodule

bind rx_out_gate rx_out_gate_chk #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) chk_i (
  .clk(clk), .rstN(rstN), .runEn(runEn), .lockIn(lockIn), .outEn(outEn),
  .dataOut(dataOut), .ctrlOut(ctrlOut), .releaseQ(releaseQ),
  .holdLowQ(holdLowQ), .capBusy(capBusy)
);

// File: tb/rx_out_gate_tb_top.sv
`timescale 1ns/1ps
module rx_out_gate_tb_top;
  localparam int DW  = 24;
  localparam int CW  = 3;
  localparam int CAP = 4;

  logic          clk = 1'b0;
  logic          rstN, runEn, lockIn, regWrEn, regWrData, pixClkIn;
  logic [DW-1:0] padIn, dataIn;
  logic [CW-1:0] ctrlIn;
  logic [DW-1:0] dataOut, strapWord;
  logic [CW-1:0] ctrlOut;
  logic          clkOut, outEn;

  int  total = 0;
  int  bad   = 0;
  bit  doneFlag = 0;

  // bench-side model state
  int            mPhase = 0;   // 0 sleep, 1 capture, 2 run
  int            mCnt   = 0;
  logic [DW-1:0] mStrap = '0;
  logic          mRel   = 1'b0;
  logic [DW-1:0] eData;
  logic [CW-1:0] eCtrl;
  logic          eEn, ePass;
  string         autoTag;

  always #2.5 clk = ~clk;  // 200 MHz

  rx_out_gate dut_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .lockIn(lockIn),
    .regWrEn(regWrEn), .regWrData(regWrData), .padIn(padIn),
    .dataIn(dataIn), .ctrlIn(ctrlIn), .pixClkIn(pixClkIn),
    .dataOut(dataOut), .ctrlOut(ctrlOut), .clkOut(clkOut),
    .outEn(outEn), .strapWord(strapWord)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // advance the model by one rising edge using the inputs present now
  task automatic modelEdge();
    logic hl, sl;
    hl = mStrap[20];
    sl = mStrap[18] | hl;
    ePass = 1'b0;
    eEn   = 1'b0;
    if (!runEn) begin
      eEn = sl; autoTag = "R2";
    end else if (mPhase != 2) begin
      autoTag = "R3";
    end else if (!lockIn) begin
      eEn = sl; autoTag = "R5";
    end else begin
      eEn = 1'b1;
      ePass = !hl || mRel;
      autoTag = !hl ? "R6" : (ePass ? "R8" : "R7");
    end
    eData = ePass ? dataIn : '0;
    eCtrl = ePass ? ctrlIn : '0;
    if (runEn && mPhase == 2 && lockIn) begin
      if (regWrEn) mRel = regWrData;
    end else begin
      mRel = 1'b0;
    end
    if (!runEn) begin
      mPhase = 0;
    end else if (mPhase == 0) begin
      mPhase = 1; mCnt = 1;
    end else if (mPhase == 1) begin
      if (mCnt == CAP - 1) begin mPhase = 2; mStrap = padIn; end
      else mCnt++;
    end
  endtask

  task automatic tick(string tagOverride);
    string t;
    @(posedge clk);
    modelEdge();
    #1;
    t = (tagOverride != "") ? tagOverride : autoTag;
    chk(t, "outEn", 32'(outEn), 32'(eEn));
    chk(t, "dataOut", 32'(dataOut), 32'(eData));
    chk(t, "ctrlOut", 32'(ctrlOut), 32'(eCtrl));
    chk("R11", "clkOut", 32'(clkOut), 32'(ePass & pixClkIn));
    chk("R4", "strapWord", 32'(strapWord), 32'(mStrap));
  endtask

  task automatic newData();
    dataIn   = DW'($urandom);
    ctrlIn   = CW'($urandom);
    pixClkIn = 1'($urandom);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #900_000;
    total++; bad++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; runEn = 1'b0; lockIn = 1'b0; regWrEn = 1'b0; regWrData = 1'b0;
    padIn = '1; dataIn = '1; ctrlIn = '1; pixClkIn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: pads float and everything zero in reset
    chk("R1", "outEn", 32'(outEn), 0);
    chk("R1", "dataOut", 32'(dataOut), 0);
    chk("R1", "clkOut", 32'(clkOut), 0);
    chk("R1", "strapWord", 32'(strapWord), 0);
    rstN = 1'b1;

    // R2: power-down with no straps captured -> high impedance
    tick(""); tick("");

    // R3: window of four edges, capture at the fourth
    runEn = 1'b1; lockIn = 1'b1; padIn = 24'hABCDEF; newData();
    tick(""); tick(""); tick("");
    padIn = 24'h041234;          // sleep select 1, hold-low 0
    tick("");
    // R6: live data passes
    for (int i = 0; i < 6; i++) begin newData(); padIn = DW'($urandom); tick(""); end
    // R5: unlocked, sleep select 1 -> driven low
    lockIn = 1'b0; tick(""); tick("");
    // R2 and R4: straps persist across power-down
    runEn = 1'b0; tick(""); tick("");

    // hold-low strap
    runEn = 1'b1; padIn = 24'h100000;
    repeat (CAP) tick("R3");
    tick("R5");
    // R9: write while unlocked is ignored
    regWrEn = 1'b1; regWrData = 1'b1; tick("R9");
    regWrEn = 1'b0; lockIn = 1'b1; newData(); tick("R9"); newData(); tick("R7");
    // R8: release write, pass from next edge
    regWrEn = 1'b1; regWrData = 1'b1; newData(); tick("R8");
    regWrEn = 1'b0; newData(); tick("R8"); newData(); tick("R8");
    // R9: relock re-arms the hold
    lockIn = 1'b0; tick("R9");
    lockIn = 1'b1; newData(); tick("R9");
    regWrEn = 1'b1; newData(); tick("R8");
    regWrEn = 1'b0; newData(); tick("R8");
    // R10: power-down clears the release bit
    runEn = 1'b0; tick("R10");
    runEn = 1'b1; repeat (CAP) tick("R3");
    newData(); tick("R10"); newData(); tick("R10");
    // R8: write 0 restores hold
    regWrEn = 1'b1; regWrData = 1'b1; newData(); tick("R8");
    regWrData = 1'b0; newData(); tick("R8");
    regWrEn = 1'b0; newData(); tick("R8"); newData(); tick("R8");

    // seeded random phase
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 50) == 0) runEn = ~runEn;
      else if (!runEn && ($urandom % 4) == 0) runEn = 1'b1;
      if (($urandom % 8) == 0) lockIn = ~lockIn;
      regWrEn   = (($urandom % 6) == 0);
      regWrData = 1'($urandom);
      padIn     = DW'($urandom);
      newData();
      tick("");
    end
    finishRun();
  end
endmodule